// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Fall-Through Read

This block is a first-in first-out buffer between two clock domains. A producer writes words on its own clock and a consumer reads them on a second clock. The two clocks may be unrelated or may be the same net. Each side has one status flag, registered in that side's clock domain. Read and write pointers cross between the domains as Gray code through a chain of synchronizer flops. A flag can therefore report "full" or "empty" for a few cycles after the far side has already freed a slot or added a word. A flag never reports a state that lets an unsafe transfer happen.

The read side works in one of two modes, captured while master reset is held. In the standard mode a word stays in storage until a read strobe moves it to the output register. In the fall-through mode the oldest word moves to the output on its own, and the read strobe consumes it. The meaning of the two flags changes with the mode. A partial reset empties the buffer but keeps the mode captured at the last master reset.

Top module: `xclk_fifo`

## Requirements
- R1: After a master reset in the standard mode, the read flag is 1 (empty), the write flag is 0 (not full) and the read data is 0. After a master reset in the fall-through mode, the read flag is 0 (no valid output) and the write flag is 1 (space available).
- R2: Words leave the read port in exactly the order they entered the write port, with no loss or duplication.
- R3: In the standard mode, the read data changes only on a rising read-clock edge where the read enable is 1 and the read flag is 0. A word written into an empty buffer does not reach the output until such a read.
- R4: In the fall-through mode, once the buffer holds a word and the output is not valid, that word is loaded into the output and the read flag goes to 1 without any read enable.
- R5: In the fall-through mode, while the read flag is 1 and the read enable is 0, the output word and the flag hold. Each read enable while the flag is 1 consumes the shown word and presents the next one, or drops the flag if none is stored.
- R6: In the standard mode, the write flag goes to 1 right after the write that fills the last of the 2^ADDR_W slots. A write while the flag is 1 is discarded and does not overwrite stored data.
- R7: A read enable while no data is available (standard: read flag 1, fall-through: read flag 0) is ignored. The output and the read pointer stay unchanged.
- R8: A partial reset discards every stored word and any shown output word. Afterwards both flags show "no data, space available" in the current mode.
- R9: The mode input is sampled only while master reset is 1: 0 selects standard, 1 selects fall-through. A change of the mode input at any other time, including during a partial reset, has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-domain clock |
| wr_en | input | 1 | Write strobe, sampled on the rising wr_clk edge |
| wr_data | input | DATA_W | Word to store |
| wr_flag | output | 1 | Standard mode: 1 = full. Fall-through mode: 1 = ready to accept |
| rd_clk | input | 1 | Read-domain clock |
| rd_en | input | 1 | Read strobe, sampled on the rising rd_clk edge |
| rd_data | output | DATA_W | Output word register |
| rd_flag | output | 1 | Standard mode: 1 = empty. Fall-through mode: 1 = rd_data holds a valid word |
| mst_rst | input | 1 | Master reset: flushes both domains and captures the mode |
| part_rst | input | 1 | Partial reset: flushes both domains and keeps the mode |
| ft_sel | input | 1 | Mode select, sampled during master reset (1 = fall-through) |

## Verification
The bench builds the block with a 16-bit word and ADDR_W = 3, which gives eight slots. With eight slots the full boundary, the discarded write beyond it and the wrap back to empty all occur within a short vector table. Both ports run from one clock. This makes the synchronizer latency a fixed, known number of cycles, so the bench can sample each flag at a chosen point after the flag has settled. The bench then runs both modes, including a partial reset that changes the mode input, to show that the captured mode survives.

// File: rtl/xclk_fifo_pkg.sv
package xclk_fifo_pkg;

   function automatic logic [31:0] to_gray(input logic [31:0] b);
      return b ^ (b >> 1);
   endfunction

endpackage

// File: rtl/xclk_fifo_sync.sv
module xclk_fifo_sync #(
   parameter int W      = 7,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (rst) stg[0] <= '0;
               else     stg[0] <= d;
            end
         end else begin : g_rest
            always_ff @(posedge clk) begin
               if (rst) stg[s] <= '0;
               else     stg[s] <= stg[s-1];
            end
         end
      end
   endgenerate

   assign q = stg[STAGES-1];
endmodule

// File: rtl/xclk_fifo_mem.sv
module xclk_fifo_mem #(
   parameter int DATA_W = 80,
   parameter int ADDR_W = 6
) (
   input  logic              wclk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge wclk) begin
      if (we) cells[waddr] <= wdata;
   end

   assign rdata = cells[raddr];
endmodule

// File: rtl/xclk_fifo_wptr.sv
module xclk_fifo_wptr
   import xclk_fifo_pkg::*;
#(
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [ADDR_W:0]   rq_gray,
   output logic              full,
   output logic              fire,
   output logic [ADDR_W-1:0] waddr,
   output logic [ADDR_W:0]   wgray
);
   localparam int PW = ADDR_W + 1;

   logic [PW-1:0] wbin;
   logic [PW-1:0] wbin_nxt;
   logic [31:0]   gray_wide;

   assign full     = (wgray == {~rq_gray[ADDR_W:ADDR_W-1], rq_gray[ADDR_W-2:0]});
   assign fire     = wr_en && !full;
   assign wbin_nxt = wbin + 1'b1;
   assign gray_wide = to_gray(32'(wbin_nxt));
   assign waddr    = wbin[ADDR_W-1:0];

   always_ff @(posedge clk) begin
      if (rst) begin
         wbin  <= '0;
         wgray <= '0;
      end else if (fire) begin
         wbin  <= wbin_nxt;
         wgray <= gray_wide[PW-1:0];
      end
   end

   // R6
   wr_full_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && full) |=> $stable(wbin));
endmodule

// File: rtl/xclk_fifo_rptr.sv
module xclk_fifo_rptr
   import xclk_fifo_pkg::*;
#(
   parameter int DATA_W = 80,
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ft,
   input  logic              rd_en,
   input  logic [ADDR_W:0]   wq_gray,
   input  logic [DATA_W-1:0] mem_q,
   output logic [ADDR_W-1:0] raddr,
   output logic [ADDR_W:0]   rgray,
   output logic [DATA_W-1:0] dout,
   output logic              flag
);
   localparam int PW = ADDR_W + 1;

   logic [PW-1:0] rbin;
   logic [PW-1:0] rbin_nxt;
   logic [31:0]   gray_wide;
   logic          empty;
   logic          shown;
   logic          pop;

   assign empty     = (rgray == wq_gray);
   assign pop       = !empty && (ft ? (!shown || rd_en) : rd_en);
   assign rbin_nxt  = rbin + 1'b1;
   assign gray_wide = to_gray(32'(rbin_nxt));
   assign raddr     = rbin[ADDR_W-1:0];
   assign flag      = ft ? shown : empty;

   always_ff @(posedge clk) begin
      if (rst) begin
         rbin  <= '0;
         rgray <= '0;
         dout  <= '0;
         shown <= 1'b0;
      end else begin
         if (pop) begin
            rbin  <= rbin_nxt;
            rgray <= gray_wide[PW-1:0];
            dout  <= mem_q;
         end
         if (!ft)        shown <= 1'b0;
         else if (pop)   shown <= 1'b1;
         else if (rd_en) shown <= 1'b0;
      end
   end

   // R7
   rd_empty_hold_chk: assert property (@(posedge clk) disable iff (rst)
      empty |=> $stable(rbin));

   // R3
   std_out_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!ft && !rd_en) |=> $stable(dout));

   // R4
   ft_autoload_chk: assert property (@(posedge clk) disable iff (rst)
      (ft && !shown && !empty) |=> shown);

   // R5
   ft_out_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (ft && shown && !rd_en) |=> (shown && $stable(dout)));
endmodule

// File: rtl/xclk_fifo.sv
module xclk_fifo #(
   parameter int DATA_W      = 80,
   parameter int ADDR_W      = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic              wr_clk,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_flag,
   input  logic              rd_clk,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_flag,
   input  logic              mst_rst,
   input  logic              part_rst,
   input  logic              ft_sel
);
   localparam int PW = ADDR_W + 1;

   generate
      if (ADDR_W < 2) begin : g_bad_addr
         $error("xclk_fifo: ADDR_W must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("xclk_fifo: SYNC_STAGES must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("xclk_fifo: DATA_W must be positive");
      end
   endgenerate

   logic              w_rst, r_rst;
   logic              ft_w, ft_r;
   logic              full, fire;
   logic [ADDR_W-1:0] waddr, raddr;
   logic [PW-1:0]     wgray, rgray, wgray_s, rgray_s;
   logic [DATA_W-1:0] mem_q;

   assign w_rst = mst_rst | part_rst;
   assign r_rst = mst_rst | part_rst;

   always_ff @(posedge wr_clk) begin
      if (mst_rst) ft_w <= ft_sel;
   end

   always_ff @(posedge rd_clk) begin
      if (mst_rst) ft_r <= ft_sel;
   end

   xclk_fifo_wptr #(.ADDR_W(ADDR_W)) u_wptr (
      .clk(wr_clk), .rst(w_rst), .wr_en(wr_en), .rq_gray(rgray_s),
      .full(full), .fire(fire), .waddr(waddr), .wgray(wgray)
   );

   xclk_fifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
      .clk(wr_clk), .rst(w_rst), .d(rgray), .q(rgray_s)
   );

   xclk_fifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
      .clk(rd_clk), .rst(r_rst), .d(wgray), .q(wgray_s)
   );

   xclk_fifo_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
      .wclk(wr_clk), .we(fire), .waddr(waddr), .wdata(wr_data),
      .raddr(raddr), .rdata(mem_q)
   );

   xclk_fifo_rptr #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rptr (
      .clk(rd_clk), .rst(r_rst), .ft(ft_r), .rd_en(rd_en),
      .wq_gray(wgray_s), .mem_q(mem_q), .raddr(raddr), .rgray(rgray),
      .dout(rd_data), .flag(rd_flag)
   );

   assign wr_flag = ft_w ? !full : full;
endmodule

// File: tb/xclk_fifo_tb.sv
module xclk_fifo_tb;
   localparam int DW = 16;
   localparam int AW = 3;
   localparam int NV = 1 << AW;
   localparam logic [DW-1:0] VEC [NV] = '{16'hA001, 16'h5A5A, 16'hFFFF, 16'h0000,
                                          16'h1357, 16'hC0DE, 16'h8000, 16'h0001};

   logic          clk = 1'b0;
   logic          wr_en = 1'b0, rd_en = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic          mst_rst = 1'b1, part_rst = 1'b0, ft_sel = 1'b0;
   logic          wr_flag, rd_flag;
   logic [DW-1:0] rd_data;
   int            n_chk = 0, n_fail = 0;
   bit            done = 1'b0;

   always #2.5 clk = ~clk;

   xclk_fifo #(.DATA_W(DW), .ADDR_W(AW), .SYNC_STAGES(2)) u_dut (
      .wr_clk(clk), .wr_en(wr_en), .wr_data(wr_data), .wr_flag(wr_flag),
      .rd_clk(clk), .rd_en(rd_en), .rd_data(rd_data), .rd_flag(rd_flag),
      .mst_rst(mst_rst), .part_rst(part_rst), .ft_sel(ft_sel)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_reset(input bit master, input bit mode);
      @(negedge clk);
      ft_sel = mode;
      if (master) mst_rst = 1'b1; else part_rst = 1'b1;
      repeat (3) @(negedge clk);
      mst_rst  = 1'b0;
      part_rst = 1'b0;
      @(negedge clk);
   endtask

   task automatic push(input logic [DW-1:0] w);
      wr_en = 1'b1; wr_data = w;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic pulse_rd;
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      // standard mode
      do_reset(1'b1, 1'b0);
      check("R1 std empty", rd_flag, 1);
      check("R1 std full", wr_flag, 0);
      check("R1 data", rd_data, 0);

      // R6: fill from the vector table
      for (int i = 0; i < NV; i++) begin
         wr_en = 1'b1; wr_data = VEC[i];
         @(negedge clk);
      end
      wr_en = 1'b0;
      check("R6 full", wr_flag, 1);
      push(16'hDEAD);
      check("R6 full held", wr_flag, 1);
      repeat (4) @(negedge clk);
      check("R3 no read", rd_data, 0);

      // R2: drain in order
      for (int i = 0; i < NV; i++) begin
         pulse_rd();
         check("R2 order", rd_data, VEC[i]);
      end
      check("R6 overflow dropped", rd_flag, 1);
      repeat (3) @(negedge clk);
      check("R6 full clear", wr_flag, 0);

      // R7: read while empty
      pulse_rd();
      check("R7 data held", rd_data, VEC[NV-1]);
      check("R7 still empty", rd_flag, 1);
      push(16'h1234);
      repeat (4) @(negedge clk);
      check("R3 written not shown", rd_data, VEC[NV-1]);
      check("R3 not empty", rd_flag, 0);
      pulse_rd();
      check("R7 next word", rd_data, 16'h1234);

      // fall-through mode
      do_reset(1'b1, 1'b1);
      check("R1 ft no valid", rd_flag, 0);
      check("R1 ft ready", wr_flag, 1);
      push(16'h00A1); push(16'h00B2); push(16'h00C3);
      repeat (5) @(negedge clk);
      check("R4 valid", rd_flag, 1);
      check("R4 first word", rd_data, 16'h00A1);
      repeat (4) @(negedge clk);
      check("R5 hold", rd_data, 16'h00A1);
      pulse_rd();
      check("R5 second", rd_data, 16'h00B2);
      pulse_rd();
      check("R5 third", rd_data, 16'h00C3);
      check("R5 valid third", rd_flag, 1);
      pulse_rd();
      check("R5 drained", rd_flag, 0);
      pulse_rd();
      check("R7 ft ignored", rd_flag, 0);

      // R8 / R9: partial reset keeps fall-through even with mode input 0
      push(16'h00D4);
      repeat (5) @(negedge clk);
      check("R8 pre word", rd_flag, 1);
      do_reset(1'b0, 1'b0);
      check("R8 no valid", rd_flag, 0);
      check("R8 ready", wr_flag, 1);
      repeat (5) @(negedge clk);
      check("R8 flushed", rd_flag, 0);
      push(16'h00E5);
      repeat (5) @(negedge clk);
      check("R9 mode kept", rd_flag, 1);
      check("R9 word shown", rd_data, 16'h00E5);

      // R9: master reset back to standard
      do_reset(1'b1, 1'b0);
      ft_sel = 1'b1;
      check("R9 std empty", rd_flag, 1);
      push(16'h00F6);
      repeat (5) @(negedge clk);
      check("R9 std no autoload", rd_data, 0);
      pulse_rd();
      check("R9 std read", rd_data, 16'h00F6);

      finish_run();
   end
endmodule